// File: doc/BRIEF.md
# Asynchronous serial byte receiver with break recovery

This block receives 8N1 asynchronous serial bytes (one start bit, eight data bits, one stop bit, no parity). It runs on the system clock and advances its bit timing only on cycles where a one-cycle `tick` strobe is high. The strobe comes at eight times the baud rate. The serial line first passes through a flop synchroniser. While enabled and idle, the receiver watches for a low level on a tick. From that point it takes eight data samples near the middle of each bit, least-significant bit first, and then tests the stop bit.

A frame whose stop bit is high is written into an eight-entry receive FIFO. A stop bit that reads low means a framing error or a break. In that case the byte is thrown away and a sticky error flag is raised. The receiver then stays parked until the line is seen high again, so a long break produces one error only and never a flood of bogus frames. A good byte that arrives while the FIFO is full is dropped and raises a sticky overrun flag. Both flags stay set until `err_clr` is pulsed.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, `fifo_nempty`, `frame_err` and `overrun` are 0.
- R2: While `en` is high and the receiver is idle, a synchronised line level of 0 seen on a tick starts a frame.
- R3: The first data bit is sampled on the 12th tick after the tick that detected the start. Each following bit is sampled 8 ticks after the previous one, 8 samples in all. The first sample goes to `rd_data[0]` and the last to `rd_data[7]`.
- R4: The stop bit is sampled 8 ticks after the last data sample. If it is 1, the byte is written to the FIFO and `fifo_nempty` goes to 1.
- R5: If the stop bit is 0, nothing is written to the FIFO and `frame_err` becomes 1.
- R6: After a framing error, the receiver does not look for a new start until it has seen the line high on a tick. A low period of any length gives one error and no byte, and a correct frame after the line returns high is received intact.
- R7: `frame_err` and `overrun` stay at 1 until `err_clr` is high for a cycle, which returns them to 0.
- R8: The FIFO holds 8 bytes in arrival order. `rd_data` shows the oldest byte whenever `fifo_nempty` is 1, and `rd_en` removes that byte.
- R9: A good byte that completes while the FIFO holds 8 bytes is dropped and sets `overrun`. The stored bytes are unchanged.
- R10: While `en` is 0, the receiver returns to idle and ignores the line: no byte is stored and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable |
| tick | input | 1 | One-cycle strobe at 8x the baud rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| err_clr | input | 1 | Clears the sticky framing-error and overrun flags |
| rd_en | input | 1 | Pops the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| fifo_nempty | output | 1 | FIFO holds at least one byte |
| frame_err | output | 1 | Sticky framing-error / break flag |
| overrun | output | 1 | Sticky flag: a good byte was dropped on a full FIFO |

## Verification
The hardest situation to reach is a stop bit that reads low while the line then stays low far longer than one frame. Only that case shows whether the receiver really stays parked or starts re-framing the break. The bench holds the line low for many frame times after a start and checks that the FIFO stays empty with the error raised. It then releases the line and sends a normal frame, which must arrive intact. Overrun needs nine frames in a row with no reads in between, and the bench then drains the FIFO to confirm that the ninth byte never entered.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   typedef enum logic [1:0] {
      RXS_IDLE = 2'd0,
      RXS_DATA = 2'd1,
      RXS_STOP = 2'd2,
      RXS_HOLD = 2'd3
   } rxs_state_e;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      if (STAGES < 2) $error("rxb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxb_framer.sv
module rxb_framer
   import rxb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int FIRST_DLY = 12,
   parameter int BIT_TICKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              line,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              err_evt
);
   localparam int CNT_W = $clog2(FIRST_DLY);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   initial begin
      if (BIT_TICKS > FIRST_DLY) $error("rxb_framer: BIT_TICKS must not exceed FIRST_DLY");
      if (BIT_TICKS < 2)         $error("rxb_framer: BIT_TICKS must be at least 2");
   end

   rxs_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RXS_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         push    <= 1'b0;
         err_evt <= 1'b0;
      end else begin
         push    <= 1'b0;
         err_evt <= 1'b0;
         if (!en) begin
            state <= RXS_IDLE;
         end else if (tick) begin
            case (state)
               RXS_IDLE: begin
                  if (!line) begin
                     state <= RXS_DATA;
                     cnt   <= CNT_W'(FIRST_DLY - 1);
                     idx   <= '0;
                  end
               end
               RXS_DATA: begin
                  if (cnt == '0) begin
                     shreg <= {line, shreg[DATA_W-1:1]};
                     cnt   <= CNT_W'(BIT_TICKS - 1);
                     if (idx == IDX_W'(DATA_W - 1)) state <= RXS_STOP;
                     else                           idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               RXS_STOP: begin
                  if (cnt == '0) begin
                     if (line) begin
                        push  <= 1'b1;
                        state <= RXS_IDLE;
                     end else begin
                        err_evt <= 1'b1;
                        state   <= RXS_HOLD;
                     end
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               RXS_HOLD: begin
                  if (line) state <= RXS_IDLE;
               end
               default: state <= RXS_IDLE;
            endcase
         end
      end
   end

   assign push_data = shreg;
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     rd,
   output logic [DATA_W-1:0]        rdata,
   output logic                     full,
   output logic                     nempty,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("rxb_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic              do_wr, do_rd;

   assign full   = (level == LVL_W'(DEPTH));
   assign nempty = (level != '0);
   assign do_wr  = wr && !full;
   assign do_rd  = rd && nempty;
   assign rdata  = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata;
   end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 8,
   parameter int FIRST_DLY   = 12,
   parameter int BIT_TICKS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rx_line,
   input  logic              err_clr,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              fifo_nempty,
   output logic              frame_err,
   output logic              overrun
);
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic              line_s;
   logic              push, err_evt, full;
   logic [DATA_W-1:0] push_data;
   logic [LVL_W-1:0]  level;

   rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
   );

   rxb_framer #(.DATA_W(DATA_W), .FIRST_DLY(FIRST_DLY), .BIT_TICKS(BIT_TICKS)) u_framer (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .line(line_s),
      .push(push), .push_data(push_data), .err_evt(err_evt)
   );

   rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(push), .wdata(push_data), .rd(rd_en),
      .rdata(rd_data), .full(full), .nempty(fifo_nempty), .level(level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_err <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         if (err_evt)          frame_err <= 1'b1;
         else if (err_clr)     frame_err <= 1'b0;
         if (push && full)     overrun   <= 1'b1;
         else if (err_clr)     overrun   <= 1'b0;
      end
   end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
   parameter int DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       en,
   input logic                       err_clr,
   input logic                       frame_err,
   input logic                       overrun,
   input logic                       push,
   input logic                       err_evt,
   input logic                       full,
   input logic                       fifo_nempty,
   input logic [$clog2(DEPTH+1)-1:0] level
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= ($clog2(DEPTH+1))'(DEPTH)); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && !err_clr) |=> frame_err); // R7
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !err_clr) |=> overrun); // R7
   AST_BAD_STOP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |-> !push); // R5
   AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> frame_err); // R5
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (overrun && fifo_nempty)); // R9
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> (!push && !err_evt)); // R10
endmodule

bind uart_rx_brk rxb_checker #(.DEPTH(DEPTH)) u_rxb_checker (
   .clk(clk), .rst_n(rst_n), .en(en), .err_clr(err_clr),
   .frame_err(frame_err), .overrun(overrun), .push(push), .err_evt(err_evt),
   .full(full), .fifo_nempty(fifo_nempty), .level(level)
);

// File: tb/tb_uart_rx_brk.sv
`timescale 1ns/1ps
module tb_uart_rx_brk;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b1;
   logic       rx_line = 1'b1;
   logic       err_clr = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       fifo_nempty, frame_err, overrun;
   logic [1:0] tdiv = '0;
   logic       tick;
   int         n_chk = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   always @(posedge clk) tdiv <= tdiv + 2'd1;
   assign tick = (tdiv == 2'd0);

   uart_rx_brk dut (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rx_line(rx_line),
      .err_clr(err_clr), .rd_en(rd_en), .rd_data(rd_data),
      .fifo_nempty(fifo_nempty), .frame_err(frame_err), .overrun(overrun)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         do @(posedge clk); while (!tick);
      end
      @(negedge clk);
   endtask

   task automatic drive_bit(input logic b);
      rx_line = b;
      wait_ticks(8);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic stop_b);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      drive_bit(stop_b);
      rx_line = 1'b1;
      wait_ticks(16);
   endtask

   task automatic pop_expect(input string req, input logic [7:0] exp);
      check(req, {7'd0, fifo_nempty}, 8'd1);
      check(req, rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_clear();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 nempty", {7'd0, fifo_nempty}, 8'd0);
      check("R1 frame_err", {7'd0, frame_err}, 8'd0);
      check("R1 overrun", {7'd0, overrun}, 8'd0);
   endtask

   task automatic t_basic();
      send_frame(8'hA5, 1'b1);
      check("R4 stored", {7'd0, fifo_nempty}, 8'd1);
      pop_expect("R3 lsb-first A5", 8'hA5);
      send_frame(8'h01, 1'b1);
      pop_expect("R2 R3 single low bit0", 8'h01);
      send_frame(8'h80, 1'b1);
      pop_expect("R3 msb only", 8'h80);
      send_frame(8'h00, 1'b1);
      pop_expect("R3 all zero", 8'h00);
      send_frame(8'hFF, 1'b1);
      pop_expect("R3 all one", 8'hFF);
      check("R8 drained", {7'd0, fifo_nempty}, 8'd0);
      check("R4 no error", {7'd0, frame_err}, 8'd0);
   endtask

   task automatic t_frame_err();
      send_frame(8'h3C, 1'b0);
      check("R5 no byte", {7'd0, fifo_nempty}, 8'd0);
      check("R5 frame_err set", {7'd0, frame_err}, 8'd1);
      wait_ticks(40);
      check("R7 err held", {7'd0, frame_err}, 8'd1);
      pulse_clear();
      check("R7 err cleared", {7'd0, frame_err}, 8'd0);
      send_frame(8'h5A, 1'b1);
      pop_expect("R6 after error", 8'h5A);
   endtask

   task automatic t_break();
      rx_line = 1'b0;
      wait_ticks(400);
      check("R6 break no byte", {7'd0, fifo_nempty}, 8'd0);
      check("R6 break err", {7'd0, frame_err}, 8'd1);
      pulse_clear();
      wait_ticks(100);
      check("R6 parked no new err", {7'd0, frame_err}, 8'd0);
      rx_line = 1'b1;
      wait_ticks(16);
      send_frame(8'hC3, 1'b1);
      pop_expect("R6 byte after break", 8'hC3);
      check("R6 single byte", {7'd0, fifo_nempty}, 8'd0);
      check("R6 no err after good", {7'd0, frame_err}, 8'd0);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 8; i++) send_frame(8'(8'h10 + i), 1'b1);
      check("R8 full no overrun", {7'd0, overrun}, 8'd0);
      send_frame(8'hEE, 1'b1);
      check("R9 overrun set", {7'd0, overrun}, 8'd1);
      for (int i = 0; i < 8; i++) pop_expect("R8 R9 order", 8'(8'h10 + i));
      check("R9 ninth dropped", {7'd0, fifo_nempty}, 8'd0);
      check("R7 overrun held", {7'd0, overrun}, 8'd1);
      pulse_clear();
      check("R7 overrun cleared", {7'd0, overrun}, 8'd0);
   endtask

   task automatic t_disable();
      en = 1'b0;
      @(negedge clk);
      send_frame(8'h69, 1'b1);
      send_frame(8'h96, 1'b0);
      check("R10 no byte", {7'd0, fifo_nempty}, 8'd0);
      check("R10 no err", {7'd0, frame_err}, 8'd0);
      en = 1'b1;
      wait_ticks(4);
      send_frame(8'h4B, 1'b1);
      pop_expect("R10 re-enabled", 8'h4B);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      wait_ticks(20);
      t_reset();
      t_basic();
      t_frame_err();
      t_break();
      t_overrun();
      t_disable();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule